// File: doc/BRIEF.md
# Interval-Based Lane Mode Controller

This controller decides, once per fixed-length interval, whether a group of switchable package lanes should carry memory data or supply extra current to the die. It counts last-level read-miss and write-miss pulses during each interval. It keeps saturating totals for the three most recently completed intervals. At each interval boundary it applies a rule set chosen by the current mode. In data mode the core runs at its lower clock. In power mode the core runs at its higher clock.

A mode change is a timed sequence. When the controller returns to data mode, it lowers the clock select before anything else. When it enters power mode, it raises the clock select only after the lanes have changed. Between these steps a settle window holds `busy` high, and no new decision can be taken during it. A decision that later proves wrong is revisited only at the next interval boundary. The interval length, the settle length, the counter width and all six thresholds are parameters. The defaults describe a 1 ms interval and a 20 µs settle window at 100 MHz.

Top module: `pinmode_ctrl`

## Requirements
- R1: After reset, `lane_pwr`, `freq_hi` and `busy` are all 0, and no interval history is held.
- R2: An interval boundary occurs every INTERVAL_CYCLES clocks after reset, and pulses in the boundary cycle count toward the interval that ends there. No mode decision is taken at the first or second boundary after reset. Decisions start at the third boundary.
- R3: The per-interval read count and the total count (reads plus writes, where both may pulse in the same cycle) saturate at 2^CNT_W-1 and never wrap.
- R4: In power mode, a boundary starts a switch to data mode only when newest total > P2IO_T3, middle total > P2IO_T2 and oldest total > P2IO_T1. All three comparisons are strict.
- R5: In data mode, a boundary starts a switch to power mode only when newest reads < IO2P_RD3, oldest reads < IO2P_RD1 and oldest total < IO2P_TOT1. All three comparisons are strict.
- R6: Entering data mode: `freq_hi` falls and `busy` rises on the same edge (the decision edge). `lane_pwr` falls on the edge where `busy` falls.
- R7: Entering power mode: `busy` rises on the decision edge, `lane_pwr` rises on the edge where `busy` falls, and `freq_hi` rises one clock after that.
- R8: `busy` stays high for exactly SETTLE_CYCLES clocks per switch. `lane_pwr` changes only as `busy` falls, and no switch starts while a sequence is in progress.
- R9: `freq_hi` is never 1 while `lane_pwr` is 0.
- R10: The three-interval history shifts at every boundary, including boundaries where a switch starts. The intervals that led to a switch therefore still affect the next decisions, and any correction waits for a later boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_miss | input | 1 | One-cycle pulse per read miss |
| wr_miss | input | 1 | One-cycle pulse per write miss |
| lane_pwr | output | 1 | 1: lanes supply power; 0: lanes carry data |
| freq_hi | output | 1 | 1: higher core clock selected; 0: lower |
| busy | output | 1 | High during the settle window of a switch |

## Verification
The bound checker checks the ordering of the outputs on every cycle. It confirms that the high clock is selected only in power mode, that the lanes move only as `busy` drops, that the clock rises exactly one cycle after the lanes enter power mode, that the clock falls as `busy` rises, and that each settle window lasts exactly SETTLE_CYCLES. Only the bench's interval patterns can show whether a switch was started for the right reasons. Those patterns cover the rule selection by mode, the strict threshold edges, saturation of heavy intervals, the three-interval warm-up, and the way history from before a switch continues to block later decisions.

// File: rtl/pinmode_ctrl.sv
module pinmode_ctrl #(
  parameter int CNT_W           = 16,
  parameter int INTERVAL_CYCLES = 100000,
  parameter int SETTLE_CYCLES   = 2000,
  parameter int P2IO_T3         = 36929,
  parameter int P2IO_T2         = 32100,
  parameter int P2IO_T1         = 3630,
  parameter int IO2P_RD3        = 1848,
  parameter int IO2P_RD1        = 9192,
  parameter int IO2P_TOT1       = 6171
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_miss,
  input  logic wr_miss,
  output logic lane_pwr,
  output logic freq_hi,
  output logic busy
);
  localparam int IW = $clog2(INTERVAL_CYCLES);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_RAISE} seq_t;

  seq_t             state;
  logic [IW-1:0]    ivl_cnt;
  logic [SW-1:0]    set_cnt;
  logic             tgt_pwr;
  logic [1:0]       hist_n;
  logic [CNT_W-1:0] rd_acc, tot_acc;
  logic [CNT_W-1:0] rd_h2, rd_h3, tot_h2, tot_h3;
  logic [CNT_W:0]   rd_sum, tot_sum;
  logic [CNT_W-1:0] rd_nx, tot_nx;
  logic             tick, decide, go_io, go_pw;

  assign tick    = ivl_cnt == IW'(INTERVAL_CYCLES - 1);
  assign rd_sum  = {1'b0, rd_acc} + {{CNT_W{1'b0}}, rd_miss};
  assign tot_sum = {1'b0, tot_acc} + {{CNT_W{1'b0}}, rd_miss} + {{CNT_W{1'b0}}, wr_miss};
  assign rd_nx   = rd_sum[CNT_W]  ? MAXC : rd_sum[CNT_W-1:0];
  assign tot_nx  = tot_sum[CNT_W] ? MAXC : tot_sum[CNT_W-1:0];

  assign go_io = lane_pwr && (tot_nx > CNT_W'(P2IO_T3)) &&
                 (tot_h3 > CNT_W'(P2IO_T2)) && (tot_h2 > CNT_W'(P2IO_T1));
  assign go_pw = !lane_pwr && (rd_nx < CNT_W'(IO2P_RD3)) &&
                 (rd_h2 < CNT_W'(IO2P_RD1)) && (tot_h2 < CNT_W'(IO2P_TOT1));
  assign decide = tick && (hist_n >= 2'd2) && (state == ST_IDLE);
  assign busy   = state == ST_SETTLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_cnt <= '0;
      rd_acc  <= '0;
      tot_acc <= '0;
      rd_h2   <= '0;
      rd_h3   <= '0;
      tot_h2  <= '0;
      tot_h3  <= '0;
      hist_n  <= '0;
    end else if (tick) begin
      ivl_cnt <= '0;
      rd_acc  <= '0;
      tot_acc <= '0;
      rd_h2   <= rd_h3;
      tot_h2  <= tot_h3;
      rd_h3   <= rd_nx;
      tot_h3  <= tot_nx;
      if (hist_n != 2'd3) hist_n <= hist_n + 2'd1;
    end else begin
      ivl_cnt <= ivl_cnt + IW'(1);
      rd_acc  <= rd_nx;
      tot_acc <= tot_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      set_cnt  <= '0;
      tgt_pwr  <= 1'b0;
      lane_pwr <= 1'b0;
      freq_hi  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (decide && (go_io || go_pw)) begin
            state   <= ST_SETTLE;
            set_cnt <= SW'(SETTLE_CYCLES - 1);
            tgt_pwr <= go_pw;
            if (go_io) freq_hi <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (set_cnt == '0) begin
            lane_pwr <= tgt_pwr;
            state    <= tgt_pwr ? ST_RAISE : ST_IDLE;
          end else begin
            set_cnt <= set_cnt - SW'(1);
          end
        end
        ST_RAISE: begin
          freq_hi <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pinmode_ctrl_chk.sv
module pinmode_ctrl_chk #(
  parameter int SETTLE_CYCLES = 2000
) (
  input logic clk,
  input logic rst,
  input logic lane_pwr,
  input logic freq_hi,
  input logic busy
);
  logic [31:0] run;

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else     run <= busy ? run + 32'd1 : 32'd0;
  end

  // R9
  freq_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
    freq_hi |-> lane_pwr);

  // R8
  lane_moves_at_settle_end_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_pwr != $past(lane_pwr)) |-> $fell(busy));

  // R7
  raise_after_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lane_pwr) |=> $rose(freq_hi));

  // R6
  drop_with_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(freq_hi) |-> $rose(busy));

  // R8
  settle_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run < 32'(SETTLE_CYCLES)));

  // R8
  settle_exact_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(run) == 32'(SETTLE_CYCLES - 1)));
endmodule

bind pinmode_ctrl pinmode_ctrl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .lane_pwr(lane_pwr), .freq_hi(freq_hi), .busy(busy)
);

// File: tb/pinmode_ctrl_bench.sv
module pinmode_ctrl_bench;
  localparam int IVL = 64;
  localparam int SET = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_miss = 1'b0;
  logic wr_miss = 1'b0;
  logic lane_pwr, freq_hi, busy;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  pinmode_ctrl #(
    .CNT_W(6), .INTERVAL_CYCLES(IVL), .SETTLE_CYCLES(SET),
    .P2IO_T3(40), .P2IO_T2(30), .P2IO_T1(5),
    .IO2P_RD3(4), .IO2P_RD1(10), .IO2P_TOT1(8)
  ) u_pinmode_ctrl (
    .clk(clk), .rst(rst), .rd_miss(rd_miss), .wr_miss(wr_miss),
    .lane_pwr(lane_pwr), .freq_hi(freq_hi), .busy(busy)
  );

  // {reads, writes, lane_pwr, busy, freq_hi, requirement} just after each boundary
  localparam logic [20:0] VEC [0:15] = '{
    {7'd0,  7'd0,  3'b000, 4'd2},   // R2 first boundary, no decision
    {7'd0,  7'd0,  3'b000, 4'd2},   // R2 second boundary, no decision
    {7'd0,  7'd0,  3'b010, 4'd5},   // R5 third boundary, go to power
    {7'd50, 7'd50, 3'b101, 4'd7},   // R7 power reached
    {7'd50, 7'd50, 3'b101, 4'd4},   // R4 oldest total still low
    {7'd50, 7'd50, 3'b110, 4'd3},   // R3 saturated totals trigger data mode
    {7'd0,  7'd0,  3'b000, 4'd6},   // R6 data mode reached, old reads block
    {7'd0,  7'd0,  3'b000, 4'd10},  // R10 shifted history still blocks
    {7'd3,  7'd4,  3'b010, 4'd5},   // R5 go to power
    {7'd60, 7'd0,  3'b101, 4'd7},   // R7 power, middle total low
    {7'd40, 7'd0,  3'b101, 4'd4},   // R4 newest equals threshold
    {7'd41, 7'd0,  3'b110, 4'd4},   // R4 just above, go to data
    {7'd0,  7'd0,  3'b000, 4'd6},   // R6 data mode reached
    {7'd0,  7'd0,  3'b000, 4'd10},  // R10 oldest reads still high
    {7'd4,  7'd0,  3'b000, 4'd5},   // R5 newest reads equal threshold
    {7'd3,  7'd0,  3'b010, 4'd5}    // R5 just below, go to power
  };

  function automatic string rname(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s lane/busy/freq actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic run_interval(input int r, input int w);
    for (int i = 0; i < IVL; i++) begin
      rd_miss = (i < r);
      wr_miss = (i < w);
      @(posedge clk); #1;
    end
  endtask

  task automatic step;
    rd_miss = 1'b0;
    wr_miss = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {lane_pwr, busy, freq_hi}, 3'b000);
    rst = 1'b0;
    for (int v = 0; v < 16; v++) begin
      run_interval(int'(VEC[v][20:14]), int'(VEC[v][13:7]));
      check($sformatf("%s vector %0d", rname(int'(VEC[v][3:0])), v),
            {lane_pwr, busy, freq_hi}, VEC[v][6:4]);
    end
    // the last vector started a power entry on this edge
    for (int k = 1; k < SET; k++) step();
    check("R8 still settling", {lane_pwr, busy, freq_hi}, 3'b010);
    step();
    check("R7 lanes before clock", {lane_pwr, busy, freq_hi}, 3'b100);
    step();
    check("R7 clock raised", {lane_pwr, busy, freq_hi}, 3'b101);
    check("R9 power with high clock", {lane_pwr, busy, freq_hi}, 3'b101);
    rst = 1'b1;
    step();
    check("R1 reset mid-run", {lane_pwr, busy, freq_hi}, 3'b000);
    finish_run();
  end
endmodule